// File: doc/BRIEF.md
# 1-Wire Link-Layer Bus Monitor

This block listens passively to one open-drain 1-Wire bus line and turns the waveform into link-layer events. The line is sampled on the system clock. There are two kinds of event: a completed data slot carrying the bit that was on the bus, and a reset sequence carrying whether any device answered with a presence pulse. The monitor never drives the bus. It sits beside a bus master or on a debug tap and delivers one strobed event record per recognised slot.

All timing comes from a single elapsed-time counter. The counter restarts on the falling edge that opens a slot and again on the rising edge that ends a reset pulse. Its value is compared against four sample points: bit sample, slot end, presence sample and reset-slot end. Each sample point has a standard-speed value and an overdrive-speed value. Every value is derived from the clock frequency parameter, and a configuration input overrides it whenever that input is non-zero.

After each reset the monitor assembles the first eight received bits, least significant first, into a command byte. When that byte is one of the two overdrive-entry codes, later slots are timed with the overdrive set. A reset pulse long enough for standard speed returns the monitor to standard timing.

Top module: `owbus_link_monitor`

## Requirements
- R1: After reset `evt_valid_o` and `od_o` are 0, and no event is emitted before the bus first goes low.
- R2: A slot whose line is high again at the slot-end count emits one event with `evt_type_o` = 0 (bit). `evt_value_o` equals the line level at the bit-sample count, so a short low (write-1) gives 1 and a long low (write-0) gives 0.
- R3: When the line is still low at the slot-end count but rises before the reset limit of the current speed is exceeded, no event is emitted. The next slot is decoded normally.
- R4: A low pulse longer than the standard reset count, followed by a high line at the reset-slot-end count (measured from the rising edge), emits one event with `evt_type_o` = 1 (reset). `evt_value_o` is 1 if the line was low at the presence-sample count, and 0 if it was high.
- R5: When the line is low at the reset-slot-end count, the monitor waits for the next rising edge. It measures that low time from the previous rising edge, and if the time exceeds the reset count it treats the rise as a fresh reset.
- R6: The first eight bits after a reset, least significant first, form a command byte. Only the values 0x3C and 0x69 set `od_o` to 1. Bits after the eighth never change `od_o`.
- R7: While `od_o` is 1, data slots use the overdrive bit-sample and slot-end counts.
- R8: While `od_o` is 1, a low pulse longer than the overdrive reset count is recognised as a reset and `od_o` stays 1. A low pulse longer than the standard reset count clears `od_o` to 0.
- R9: A zero configuration input selects the default count of round(down)(CLK_HZ × time) − 1. The default times are 15 µs, 60 µs, 75 µs and 480 µs at standard speed, and 2 µs, 7.3 µs, 10 µs and 48 µs at overdrive speed. A non-zero input replaces its default.
- R10: The elapsed-time counter saturates at 2^CNT_W − 1, so a low pulse held longer than that still counts as a reset.
- R11: `evt_valid_o` is a single-cycle pulse, and it is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| bus_i | input | 1 | Raw level of the monitored bus line |
| cfg_std_bit_i | input | CNT_W | Standard bit-sample count (0 selects the default) |
| cfg_std_slot_i | input | CNT_W | Standard slot-end count (0 selects the default) |
| cfg_std_pres_i | input | CNT_W | Standard presence-sample count (0 selects the default) |
| cfg_std_rst_i | input | CNT_W | Standard reset count (0 selects the default) |
| cfg_od_bit_i | input | CNT_W | Overdrive bit-sample count (0 selects the default) |
| cfg_od_slot_i | input | CNT_W | Overdrive slot-end count (0 selects the default) |
| cfg_od_pres_i | input | CNT_W | Overdrive presence-sample count (0 selects the default) |
| cfg_od_rst_i | input | CNT_W | Overdrive reset count (0 selects the default) |
| evt_valid_o | output | 1 | One-cycle strobe marking an event |
| evt_type_o | output | 1 | 0 = data bit, 1 = reset/presence |
| evt_value_o | output | 1 | Bit value, or 1 when a presence pulse was seen |
| od_o | output | 1 | 1 while overdrive timing is selected |

## Verification
The assertions check four properties on every cycle. An event strobe never repeats on the next cycle, and an event is only emitted after the line was seen high. The counter holds at its maximum instead of wrapping. Overdrive switches on only together with a bit event and switches off only at a counter restart on a reset. Only the bench's scenarios can show the rest. These are the decoded bit and presence values for each slot shape at both speeds, and which command bytes select overdrive and which leave it. They also cover the swallowed mid-length low pulse, the re-armed reset when a device holds the line, the default versus overridden thresholds, and the very long reset that would be missed if the counter wrapped.

// File: rtl/owmon_pkg.sv
package owmon_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DSAMP,
    ST_SLOTEND,
    ST_RISE,
    ST_PRES,
    ST_RSTEND
  } mon_state_t;

  localparam logic EVT_BIT   = 1'b0;
  localparam logic EVT_RESET = 1'b1;

  // threshold table layout: four per speed, overdrive set at offset OD_OFS
  localparam int NUM_THR = 8;
  localparam int OD_OFS  = 4;
  localparam int TI_BIT  = 0;
  localparam int TI_SLOT = 1;
  localparam int TI_PRES = 2;
  localparam int TI_RST  = 3;

  // default sample time of each threshold, in tenths of a microsecond
  function automatic longint thr_tenths(input int idx);
    case (idx)
      0:       return 150;
      1:       return 600;
      2:       return 750;
      3:       return 4800;
      4:       return 20;
      5:       return 73;
      6:       return 100;
      default: return 480;
    endcase
  endfunction

  function automatic longint default_count(input longint hz, input int idx);
    return (hz * thr_tenths(idx)) / 64'd10000000 - 64'd1;
  endfunction

endpackage

// File: rtl/owmon_sync.sv
module owmon_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic line_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], raw_i};
  end

  // idle bus is pulled high, so reset to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign line_o = sync_q[STAGES-1];

endmodule

// File: rtl/owmon_timer.sv
module owmon_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = restart_i || (cnt_q != CNT_MAX);
    cnt_d  = restart_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/owmon_thresh.sv
module owmon_thresh
  import owmon_pkg::*;
#(
  parameter longint CLK_HZ = 50_000_000,
  parameter int     CNT_W  = 16
) (
  input  logic [CNT_W-1:0] cfg_i [NUM_THR],
  input  logic             od_i,
  output logic [CNT_W-1:0] bit_o,
  output logic [CNT_W-1:0] slot_o,
  output logic [CNT_W-1:0] pres_o,
  output logic [CNT_W-1:0] rst_o,
  output logic [CNT_W-1:0] rst_std_o,
  output logic [CNT_W-1:0] rst_od_o
);

  logic [CNT_W-1:0] eff [NUM_THR];

  for (genvar g = 0; g < NUM_THR; g++) begin : g_thr
    localparam logic [CNT_W-1:0] DEF = CNT_W'(default_count(CLK_HZ, g));
    assign eff[g] = (cfg_i[g] != '0) ? cfg_i[g] : DEF;
  end

  always_comb begin
    if (od_i) begin
      bit_o  = eff[OD_OFS + TI_BIT];
      slot_o = eff[OD_OFS + TI_SLOT];
      pres_o = eff[OD_OFS + TI_PRES];
      rst_o  = eff[OD_OFS + TI_RST];
    end else begin
      bit_o  = eff[TI_BIT];
      slot_o = eff[TI_SLOT];
      pres_o = eff[TI_PRES];
      rst_o  = eff[TI_RST];
    end
    rst_std_o = eff[TI_RST];
    rst_od_o  = eff[OD_OFS + TI_RST];
  end

endmodule

// File: rtl/owmon_cmd.sv
module owmon_cmd #(
  parameter int         CMD_BITS = 8,
  parameter logic [7:0] CODE_A   = 8'h3C,
  parameter logic [7:0] CODE_B   = 8'h69
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb_i,
  input  logic bit_val_i,
  input  logic clr_i,
  input  logic keep_od_i,
  output logic od_o
);

  localparam int IDX_W = $clog2(CMD_BITS + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CMD_BITS - 1);
  localparam logic [IDX_W-1:0] DONE_IDX = IDX_W'(CMD_BITS);

  logic [IDX_W-1:0]    idx_q, idx_d;
  logic [CMD_BITS-1:0] cmd_q, cmd_d;
  logic                od_q, od_d;
  logic [CMD_BITS-1:0] cmd_ins;
  logic                take;

  always_comb begin
    take    = bit_stb_i && (idx_q != DONE_IDX);
    cmd_ins = cmd_q | (CMD_BITS'(bit_val_i) << idx_q);
    idx_d   = idx_q;
    cmd_d   = cmd_q;
    od_d    = od_q;
    if (clr_i) begin
      idx_d = '0;
      cmd_d = '0;
      od_d  = od_q && keep_od_i;
    end else if (take) begin
      idx_d = idx_q + 1'b1;
      cmd_d = cmd_ins;
      if ((idx_q == LAST_IDX) &&
          ((cmd_ins == CMD_BITS'(CODE_A)) || (cmd_ins == CMD_BITS'(CODE_B)))) begin
        od_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      cmd_q <= '0;
      od_q  <= 1'b0;
    end else begin
      idx_q <= idx_d;
      cmd_q <= cmd_d;
      od_q  <= od_d;
    end
  end

  assign od_o = od_q;

endmodule

// File: rtl/owmon_fsm.sv
module owmon_fsm
  import owmon_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] thr_bit_i,
  input  logic [CNT_W-1:0] thr_slot_i,
  input  logic [CNT_W-1:0] thr_pres_i,
  input  logic [CNT_W-1:0] thr_rst_i,
  input  logic [CNT_W-1:0] thr_rst_std_i,
  input  logic [CNT_W-1:0] thr_rst_od_i,
  input  logic             od_i,
  output logic             restart_o,
  output logic             bit_stb_o,
  output logic             bit_val_o,
  output logic             clr_o,
  output logic             keep_od_o,
  output logic             evt_valid_o,
  output logic             evt_type_o,
  output logic             evt_value_o
);

  mon_state_t state_q, state_d;
  logic       smp_q, smp_d;
  logic       ev_v_d, ev_t_d, ev_x_d;
  logic       ev_v_q, ev_t_q, ev_x_q;

  always_comb begin
    state_d   = state_q;
    smp_d     = smp_q;
    restart_o = 1'b0;
    bit_stb_o = 1'b0;
    clr_o     = 1'b0;
    keep_od_o = 1'b0;
    ev_v_d    = 1'b0;
    ev_t_d    = ev_t_q;
    ev_x_d    = ev_x_q;
    case (state_q)
      ST_IDLE: begin
        if (!line_i) begin
          restart_o = 1'b1;
          state_d   = ST_DSAMP;
        end
      end
      ST_DSAMP: begin
        if (cnt_i == thr_bit_i) begin
          smp_d   = line_i;
          state_d = ST_SLOTEND;
        end
      end
      ST_SLOTEND: begin
        if (cnt_i == thr_slot_i) begin
          if (line_i) begin
            bit_stb_o = 1'b1;
            ev_v_d    = 1'b1;
            ev_t_d    = EVT_BIT;
            ev_x_d    = smp_q;
            state_d   = ST_IDLE;
          end else begin
            state_d = ST_RISE;
          end
        end
      end
      ST_RISE: begin
        if (line_i) begin
          if (cnt_i > thr_rst_std_i) begin
            restart_o = 1'b1;
            clr_o     = 1'b1;
            state_d   = ST_PRES;
          end else if (od_i && (cnt_i > thr_rst_od_i)) begin
            restart_o = 1'b1;
            clr_o     = 1'b1;
            keep_od_o = 1'b1;
            state_d   = ST_PRES;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_PRES: begin
        if (cnt_i == thr_pres_i) begin
          smp_d   = line_i;
          state_d = ST_RSTEND;
        end
      end
      ST_RSTEND: begin
        if (cnt_i == thr_rst_i) begin
          if (line_i) begin
            ev_v_d  = 1'b1;
            ev_t_d  = EVT_RESET;
            ev_x_d  = !smp_q;
            state_d = ST_IDLE;
          end else begin
            state_d = ST_RISE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      smp_q   <= 1'b1;
      ev_v_q  <= 1'b0;
      ev_t_q  <= EVT_BIT;
      ev_x_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      smp_q   <= smp_d;
      ev_v_q  <= ev_v_d;
      ev_t_q  <= ev_t_d;
      ev_x_q  <= ev_x_d;
    end
  end

  assign bit_val_o   = smp_q;
  assign evt_valid_o = ev_v_q;
  assign evt_type_o  = ev_t_q;
  assign evt_value_o = ev_x_q;

endmodule

// File: rtl/owbus_link_monitor.sv
module owbus_link_monitor
  import owmon_pkg::*;
#(
  parameter longint     CLK_HZ      = 50_000_000,
  parameter int         CNT_W       = 16,
  parameter int         SYNC_STAGES = 2,
  parameter int         CMD_BITS    = 8,
  parameter logic [7:0] OD_CODE_A   = 8'h3C,
  parameter logic [7:0] OD_CODE_B   = 8'h69
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_i,
  input  logic [CNT_W-1:0] cfg_std_bit_i,
  input  logic [CNT_W-1:0] cfg_std_slot_i,
  input  logic [CNT_W-1:0] cfg_std_pres_i,
  input  logic [CNT_W-1:0] cfg_std_rst_i,
  input  logic [CNT_W-1:0] cfg_od_bit_i,
  input  logic [CNT_W-1:0] cfg_od_slot_i,
  input  logic [CNT_W-1:0] cfg_od_pres_i,
  input  logic [CNT_W-1:0] cfg_od_rst_i,
  output logic             evt_valid_o,
  output logic             evt_type_o,
  output logic             evt_value_o,
  output logic             od_o
);

  logic             line_s;
  logic [CNT_W-1:0] elapsed;
  logic             tmr_restart;
  logic [CNT_W-1:0] cfg_arr [NUM_THR];
  logic [CNT_W-1:0] thr_bit, thr_slot, thr_pres, thr_rst, thr_rst_std, thr_rst_od;
  logic             bit_stb, bit_val, cmd_clr, keep_od, od_s;

  assign cfg_arr[TI_BIT]           = cfg_std_bit_i;
  assign cfg_arr[TI_SLOT]          = cfg_std_slot_i;
  assign cfg_arr[TI_PRES]          = cfg_std_pres_i;
  assign cfg_arr[TI_RST]           = cfg_std_rst_i;
  assign cfg_arr[OD_OFS + TI_BIT]  = cfg_od_bit_i;
  assign cfg_arr[OD_OFS + TI_SLOT] = cfg_od_slot_i;
  assign cfg_arr[OD_OFS + TI_PRES] = cfg_od_pres_i;
  assign cfg_arr[OD_OFS + TI_RST]  = cfg_od_rst_i;

  owmon_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (bus_i),
    .line_o (line_s)
  );

  owmon_timer #(.CNT_W(CNT_W)) i_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (tmr_restart),
    .cnt_o     (elapsed)
  );

  owmon_thresh #(.CLK_HZ(CLK_HZ), .CNT_W(CNT_W)) i_thresh (
    .cfg_i     (cfg_arr),
    .od_i      (od_s),
    .bit_o     (thr_bit),
    .slot_o    (thr_slot),
    .pres_o    (thr_pres),
    .rst_o     (thr_rst),
    .rst_std_o (thr_rst_std),
    .rst_od_o  (thr_rst_od)
  );

  owmon_fsm #(.CNT_W(CNT_W)) i_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .line_i        (line_s),
    .cnt_i         (elapsed),
    .thr_bit_i     (thr_bit),
    .thr_slot_i    (thr_slot),
    .thr_pres_i    (thr_pres),
    .thr_rst_i     (thr_rst),
    .thr_rst_std_i (thr_rst_std),
    .thr_rst_od_i  (thr_rst_od),
    .od_i          (od_s),
    .restart_o     (tmr_restart),
    .bit_stb_o     (bit_stb),
    .bit_val_o     (bit_val),
    .clr_o         (cmd_clr),
    .keep_od_o     (keep_od),
    .evt_valid_o   (evt_valid_o),
    .evt_type_o    (evt_type_o),
    .evt_value_o   (evt_value_o)
  );

  owmon_cmd #(.CMD_BITS(CMD_BITS), .CODE_A(OD_CODE_A), .CODE_B(OD_CODE_B)) i_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_stb_i (bit_stb),
    .bit_val_i (bit_val),
    .clr_i     (cmd_clr),
    .keep_od_i (keep_od),
    .od_o      (od_s)
  );

  assign od_o = od_s;

endmodule

// File: rtl/owmon_checker.sv
module owmon_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ln,
  input logic [CNT_W-1:0] cnt,
  input logic             restart,
  input logic             evt_valid,
  input logic             evt_type,
  input logic             od
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R11: strobe lasts one cycle
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> !evt_valid);

  // R2, R4: every event is decided while the synchronized line is high
  a_r2_event_after_high: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> $past(ln));

  // R10: the elapsed counter never wraps
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && (cnt == CNT_MAX)) |=> (cnt == CNT_MAX));

  // R6: overdrive is entered only together with a bit event
  a_r6_od_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(od) |-> (evt_valid && (evt_type == 1'b0)));

  // R8: overdrive is left only at a reset's counter restart
  a_r8_od_off_on_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(od) |-> ($past(restart) && !evt_valid));

endmodule

bind owbus_link_monitor owmon_checker #(.CNT_W(CNT_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ln        (line_s),
  .cnt       (elapsed),
  .restart   (tmr_restart),
  .evt_valid (evt_valid_o),
  .evt_type  (evt_type_o),
  .od        (od_o)
);

// File: tb/test_owbus_link_monitor.sv
`timescale 1ns/1ps
module test_owbus_link_monitor;

  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus = 1'b1;
  logic [CNT_W-1:0] c_sb = '0, c_ss = '0, c_sp = '0, c_sr = '0;
  logic [CNT_W-1:0] c_ob = '0, c_os = '0, c_op = '0, c_or = '0;
  logic evt_valid, evt_type, evt_value, od;

  int n_chk = 0;
  int n_bad = 0;
  int exp_q[$];
  logic prev_v = 1'b0;

  always #10 clk = ~clk;

  owbus_link_monitor #(.CLK_HZ(50_000_000), .CNT_W(CNT_W)) i_owbus_link_monitor (
    .clk(clk), .rst_n(rst_n), .bus_i(bus),
    .cfg_std_bit_i(c_sb), .cfg_std_slot_i(c_ss), .cfg_std_pres_i(c_sp), .cfg_std_rst_i(c_sr),
    .cfg_od_bit_i(c_ob), .cfg_od_slot_i(c_os), .cfg_od_pres_i(c_op), .cfg_od_rst_i(c_or),
    .evt_valid_o(evt_valid), .evt_type_o(evt_type), .evt_value_o(evt_value), .od_o(od)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // event monitor: compares every strobe against the reference queue (R2, R4, R11)
  always @(negedge clk) begin
    if (rst_n) begin
      if (evt_valid) begin
        int e;
        chk("R11", "strobe on consecutive cycles", int'(prev_v), 0);
        if (exp_q.size() == 0) begin
          chk("R3", "unexpected event type*2+value", int'(evt_type) * 2 + int'(evt_value), -1);
        end else begin
          e = exp_q.pop_front();
          chk(e >= 2 ? "R4" : "R2", "event type*2+value", int'(evt_type) * 2 + int'(evt_value), e);
        end
      end
      prev_v = evt_valid;
    end
  end

  task automatic hold(input logic v, input int n);
    bus = v;
    repeat (n) @(negedge clk);
  endtask

  // data slot at the small bench thresholds
  task automatic slot(input logic b, input logic fast);
    exp_q.push_back(int'(b));
    if (fast) begin
      hold(1'b0, b ? 2 : 8);
      hold(1'b1, b ? 28 : 22);
    end else begin
      hold(1'b0, b ? 5 : 40);
      hold(1'b1, b ? 95 : 60);
    end
  endtask

  task automatic rst_seq(input int low, input int p_at, input int p_len, input int tail, input logic ev);
    exp_q.push_back(2 + int'(ev));
    hold(1'b0, low);
    if (p_len > 0) begin
      hold(1'b1, p_at);
      hold(1'b0, p_len);
      hold(1'b1, tail - p_at - p_len);
    end else begin
      hold(1'b1, tail);
    end
  endtask

  task automatic std_reset(input logic present);
    rst_seq(600, 30, present ? 60 : 0, 600, present);
  endtask

  task automatic send_byte(input logic [7:0] v, input logic fast);
    for (int i = 0; i < 8; i++) slot(v[i], fast);
  endtask

  task automatic drain(input string tag);
    chk(tag, "events still pending", exp_q.size(), 0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "evt_valid in reset", int'(evt_valid), 0);
    chk("R1", "od in reset", int'(od), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R1", "od after release", int'(od), 0);
    drain("R1");

    // R9 defaults: bit sample 749, slot end 2999 at 50 MHz
    exp_q.push_back(1); hold(1'b0, 50);   hold(1'b1, 3950);
    exp_q.push_back(0); hold(1'b0, 1500); hold(1'b1, 2500);
    drain("R9");

    // R9 override with small counts
    c_sb = 20; c_ss = 60; c_sp = 75; c_sr = 480;
    c_ob = 4;  c_os = 12; c_op = 16; c_or = 96;
    repeat (10) @(negedge clk);
    exp_q.push_back(0); hold(1'b0, 50); hold(1'b1, 50);
    drain("R9");

    // R4 presence and absence
    std_reset(1'b1);
    std_reset(1'b0);
    drain("R4");
    // R2 bit patterns
    slot(1'b0, 1'b0); slot(1'b1, 1'b0); slot(1'b1, 1'b0); slot(1'b0, 1'b0);
    drain("R2");
    // R3 mid-length low: no event, next slot fine
    hold(1'b0, 300); hold(1'b1, 100);
    drain("R3");
    slot(1'b1, 1'b0);
    drain("R3");
    chk("R3", "od after mid low", int'(od), 0);

    // R5 device holds line past reset-slot end: re-armed, second reset sees no presence
    exp_q.push_back(2);
    hold(1'b0, 600); hold(1'b1, 30); hold(1'b0, 500); hold(1'b1, 600);
    drain("R5");

    // R10 low held past the counter range still counts as reset
    rst_seq(65536 + 200, 30, 60, 600, 1'b1);
    drain("R10");

    // R6 non-matching first byte, then a matching second byte
    std_reset(1'b1);
    send_byte(8'h55, 1'b0);
    chk("R6", "od after 0x55", int'(od), 0);
    send_byte(8'h69, 1'b0);
    chk("R6", "od after code past first byte", int'(od), 0);
    drain("R6");

    // R6 0x3C selects overdrive
    std_reset(1'b1);
    send_byte(8'h3C, 1'b0);
    chk("R6", "od after 0x3C", int'(od), 1);
    // R7 overdrive-timed slots
    slot(1'b0, 1'b1); slot(1'b1, 1'b1); slot(1'b0, 1'b1); slot(1'b1, 1'b1);
    drain("R7");
    // R8 overdrive reset keeps overdrive
    rst_seq(150, 5, 20, 150, 1'b1);
    drain("R8");
    chk("R8", "od after overdrive reset", int'(od), 1);
    send_byte(8'hA5, 1'b1);
    chk("R8", "od after od-speed byte", int'(od), 1);
    // R8 standard reset leaves overdrive
    std_reset(1'b1);
    chk("R8", "od after standard reset", int'(od), 0);
    slot(1'b0, 1'b0);
    drain("R8");

    // R6 0x69 also selects overdrive
    std_reset(1'b0);
    send_byte(8'h69, 1'b0);
    chk("R6", "od after 0x69", int'(od), 1);
    slot(1'b0, 1'b1);
    drain("R7");

    summary();
    $finish;
  end

endmodule